// File: doc/BRIEF.md
# Bus-Attached Arithmetic Unit

This block is an arithmetic and logic unit that hangs off a shared data bus. It holds two operands and an operation code. Each of the three registers is written from the bus under its own load strobe. Every function (add, subtract, bitwise logic, shifts and a pass-through) is evaluated on the two operands at once. A multiplexer steered by the operation register picks the one result that is offered back to the bus.

A second readable word packs a comparison of the operands with an error indication. The operands themselves can never be read back. A bus master writes the operands and the code, then strobes either the result or the flag word onto the bus.

Bus drive is modelled as a data output plus one drive-enable per source, so the surrounding fabric can merge the sources without real tri-states.

Top module: `bus_alu`

## Requirements
- R1: Operand A (resp. B) takes the full bus value on the clock edge where its load strobe is high, and keeps its value on every other edge, whatever the bus carries.
- R2: The operation register takes the low OPW bits of the bus on the edge where its load strobe is high, and holds otherwise.
- R3: The result is chosen by operation code. The codes are: 0 = A+B, 1 = A-B, 2 = A&B, 3 = A|B, 4 = A^B, 5 = A shifted left by B mod W, 6 = A shifted right (logical) by B mod W, 7 = B. Sums and differences are truncated to W bits.
- R4: The flag word carries the unsigned comparison of A and B. Bit 0 is A>B, bit 1 is A==B, bit 2 is A<B, and exactly one of these three bits is set. Bit 3 is the error bit, and bits W-1..4 are zero.
- R5: The error bit is set by carry out of code 0, by borrow (A<B) of code 1, and by any code from 8 upward. It is clear for codes 2 to 7. For codes from 8 upward the result is zero.
- R6: While the result store strobe is high, res_oe is high and bus_dout equals the selected result, in the same cycle.
- R7: While only the flag store strobe is high, flag_oe is high and bus_dout equals the flag word. If both strobes are high, the result wins and flag_oe stays low, so the two enables are never high together.
- R8: With neither store strobe high, both enables are low and bus_dout is all zero.
- R9: After reset all three registers are zero. The result then reads 0, and the flag word reads 0b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | W | Data from the shared bus |
| ld_a | input | 1 | Load strobe for operand A |
| ld_b | input | 1 | Load strobe for operand B |
| ld_op | input | 1 | Load strobe for the operation register |
| st_res | input | 1 | Store strobe: drive the result |
| st_flag | input | 1 | Store strobe: drive the flag word |
| bus_dout | output | W | Data offered to the bus |
| res_oe | output | 1 | Drive enable for the result |
| flag_oe | output | 1 | Drive enable for the flag word |

## Verification
The bench builds the unit with W=8 and OPW=4. At these widths carry, borrow, every shift distance and all sixteen operation codes, including the eight undefined ones, fall inside a short sweep. Operand pairs cover a grid of 16 values per operand, which includes 0 and the all-ones value. Each pair is checked against every code, for both result and flags. The bus is held at a different value while the store strobes are high, so any operand that fails to hold shows up in the result.

// File: rtl/bus_alu.sv
module bus_alu #(
  parameter int W   = 64,
  parameter int OPW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         ld_op,
  input  logic         st_res,
  input  logic         st_flag,
  output logic [W-1:0] bus_dout,
  output logic         res_oe,
  output logic         flag_oe
);
  localparam int SHW = $clog2(W);
  localparam int FLW = 4;

  logic [W-1:0]   a_q, b_q, res;
  logic [OPW-1:0] op_q;
  logic           err;
  logic [W:0]     sum, diff;
  logic [SHW-1:0] sh;
  logic [W-1:0]   flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
    end else begin
      if (ld_a)  a_q  <= bus_in;
      if (ld_b)  b_q  <= bus_in;
      if (ld_op) op_q <= bus_in[OPW-1:0];
    end
  end

  assign sum  = {1'b0, a_q} + {1'b0, b_q};
  assign diff = {1'b0, a_q} - {1'b0, b_q};
  assign sh   = b_q[SHW-1:0];

  always_comb begin
    res = '0;
    err = 1'b0;
    case (op_q)
      OPW'(0): begin res = sum[W-1:0];  err = sum[W];  end
      OPW'(1): begin res = diff[W-1:0]; err = diff[W]; end
      OPW'(2): res = a_q & b_q;
      OPW'(3): res = a_q | b_q;
      OPW'(4): res = a_q ^ b_q;
      OPW'(5): res = a_q << sh;
      OPW'(6): res = a_q >> sh;
      OPW'(7): res = b_q;
      default: err = 1'b1;
    endcase
  end

  assign flag = {{(W-FLW){1'b0}}, err, a_q < b_q, a_q == b_q, a_q > b_q};

  assign res_oe   = st_res;
  assign flag_oe  = st_flag & ~st_res;
  assign bus_dout = res_oe ? res : (flag_oe ? flag : '0);
endmodule

module bus_alu_chk #(
  parameter int W   = 64,
  parameter int OPW = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic         ld_a,
  input logic         ld_b,
  input logic         st_res,
  input logic         st_flag,
  input logic [W-1:0] bus_dout,
  input logic         res_oe,
  input logic         flag_oe,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [OPW-1:0] op_q
);
  p_load_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> a_q == $past(bus_in));
  p_hold_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> $stable(b_q));
  p_cmp_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe |-> $countones(bus_dout[2:0]) == 1);
  p_eq_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe |-> bus_dout[1] == (a_q == b_q));
  p_undef_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_oe && op_q >= OPW'(8)) |-> bus_dout[3]);
  p_res_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_res |-> res_oe);
  p_excl_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_oe && flag_oe));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_res && !st_flag) |-> (!res_oe && !flag_oe && bus_dout == '0));
endmodule

bind bus_alu bus_alu_chk #(.W(W), .OPW(OPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
  .st_res(st_res), .st_flag(st_flag), .bus_dout(bus_dout),
  .res_oe(res_oe), .flag_oe(flag_oe), .a_q(a_q), .b_q(b_q), .op_q(op_q)
);

// File: tb/bus_alu_tb_top.sv
module bus_alu_tb_top;
  localparam int W = 8;
  localparam int OPW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic ld_a = 0, ld_b = 0, ld_op = 0, st_res = 0, st_flag = 0;
  logic [W-1:0] bus_dout;
  logic res_oe, flag_oe;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_alu #(.W(W), .OPW(OPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
    .ld_op(ld_op), .st_res(st_res), .st_flag(st_flag),
    .bus_dout(bus_dout), .res_oe(res_oe), .flag_oe(flag_oe)
  );

  function automatic logic [W-1:0] exp_res(int a, int b, int op);
    int s = b % W;
    case (op)
      0: return W'(a + b);
      1: return W'(a - b);
      2: return W'(a & b);
      3: return W'(a | b);
      4: return W'(a ^ b);
      5: return W'(a << s);
      6: return W'(a >> s);
      7: return W'(b);
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_flag(int a, int b, int op);
    int e;
    if (op == 0) e = (a + b) > 255 ? 1 : 0;
    else if (op == 1) e = (a < b) ? 1 : 0;
    else if (op >= 8) e = 1;
    else e = 0;
    return W'(e * 8 + (a < b ? 4 : 0) + (a == b ? 2 : 0) + (a > b ? 1 : 0));
  endfunction

  task automatic check(string req, logic [W-1:0] dout, logic roe, logic foe,
                       logic [W-1:0] ed, logic er, logic ef);
    checks++;
    if (dout !== ed || roe !== er || foe !== ef) begin
      errors++;
      $display("FAIL %s: got dout=%0h res_oe=%0b flag_oe=%0b, expected dout=%0h res_oe=%0b flag_oe=%0b",
               req, dout, roe, foe, ed, er, ef);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R9: reset state, also R8 release
    #2 check("R8", bus_dout, res_oe, flag_oe, '0, 1'b0, 1'b0);
    st_res = 1; #1 check("R9", bus_dout, res_oe, flag_oe, '0, 1'b1, 1'b0);
    st_res = 0; st_flag = 1; #1 check("R9", bus_dout, res_oe, flag_oe, 8'h02, 1'b0, 1'b1);
    st_flag = 0;
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        int a = ia * 17;
        int b = ib * 17 + ((ia + ib) % 3);
        if (b > 255) b = 255;
        tick(); bus_in = W'(a); ld_a = 1;
        tick(); ld_a = 0; bus_in = W'(b); ld_b = 1;
        tick(); ld_b = 0;
        for (int op = 0; op < 16; op++) begin
          bus_in = W'(8'hF0 | op); ld_op = 1;   // R2: upper bits ignored
          tick(); ld_op = 0; bus_in = ~W'(a);   // R1: operands must hold
          st_res = 1;
          #2 check("R3/R6", bus_dout, res_oe, flag_oe, exp_res(a, b, op), 1'b1, 1'b0);
          tick(); st_res = 0; st_flag = 1;
          #2 check("R4/R5/R7", bus_dout, res_oe, flag_oe, exp_flag(a, b, op), 1'b0, 1'b1);
          if (op == 9 || op == 1) begin
            st_res = 1;
            #1 check("R7 both", bus_dout, res_oe, flag_oe, exp_res(a, b, op), 1'b1, 1'b0);
            st_flag = 0; st_res = 0;
            #1 check("R8", bus_dout, res_oe, flag_oe, '0, 1'b0, 1'b0);
          end
          tick(); st_flag = 0;
        end
      end
    end
    done = 1;
    finish_run();
  end
endmodule